// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block is the master side of a serial link to an external eight-channel, 12-bit converter. It takes one command made of a channel number, a single-ended/differential flag and a unipolar/bipolar flag, and runs one complete conversion from it. The block lowers chip select and clocks out a control byte, and it throws away the byte that arrives with it. It then clocks out two zero bytes and keeps the 16 bits that come back. Finally it raises chip select.

The 12 result bits are taken from the two kept reply bytes. They are zero-extended in unipolar mode, or sign-extended to 16 bits in bipolar mode, and are presented together with a one-cycle completion pulse. A cycle counter measures how long chip select was low. If that time exceeds the allowed conversion window, the completion pulse also carries an error flag.

The command side is a valid/ready handshake. A command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while the sequencer is idle, so a command presented during a conversion simply waits and is neither queued nor dropped. The result side has no back-pressure. `done` pulses once and `result`/`timeout_err` hold until the next completion.

Top module: `adc_conv_seq`

## Requirements
- R1: A command is accepted only on an edge with `cmd_valid` and `cmd_ready` high. `cmd_ready` is low and `busy` high from the cycle after acceptance until the cycle of `done`. `cmd_valid` asserted while busy starts nothing.
- R2: `spi_cs_n` falls only after an accepted command and rises only after the third byte. While it is low exactly 24 rising SCLK edges occur, and SCLK is low whenever `spi_cs_n` is high.
- R3: The first byte on MOSI, MSB first, is {1, chan[0], chan[2], chan[1], unipolar, single, PWR_MODE[1:0]}. In both modes the 3-bit select field is {chan[0], chan[2], chan[1]}.
- R4: The second and third bytes on MOSI are 0x00.
- R5: MISO is sampled on rising SCLK, MSB first. The 8 bits received during the first byte have no effect on the result.
- R6: With {B2,B3} the two later reply bytes, the 12-bit code is bits [14:3]. Bit 15 and bits [2:0] have no effect.
- R7: Unipolar (`cmd_unipolar`=1) gives `result` = {4'b0, code}. Bipolar gives the code sign-extended from its bit 11.
- R8: `done` is a one-cycle pulse in the same cycle that `spi_cs_n` returns high. `result` and `timeout_err` change only with `done` and hold until the next one.
- R9: `timeout_err` is 1 with `done` when chip select stayed low more than WINDOW_CYCLES clocks, otherwise 0.
- R10: Each SCLK level lasts HALF_DIV clocks. Between bytes SCLK stays low for GAP_SCLKS extra SCLK periods, so successive byte-boundary rising edges are (2+2·GAP_SCLKS)·HALF_DIV clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command can transfer |
| cmd_chan | input | 3 | Channel number 0..7 |
| cmd_single | input | 1 | 1 = single-ended, 0 = differential |
| cmd_unipolar | input | 1 | 1 = unipolar (straight binary), 0 = bipolar (two's complement) |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | Conversion window exceeded (valid with done, held) |
| result | output | 16 | Extended conversion result (held) |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to converter |
| spi_miso | input | 1 | Serial data from converter |

## Verification
A table of conversions covers every channel and both input modes. Each is paired with unipolar and bipolar codes at zero, full scale, mid-scale and mixed bit patterns. The pad positions and the discarded first reply byte are filled with ones in some rows, so that an off-by-one slice or a leak of the first byte shows in the result. The captured MOSI stream separates the channel bit permutation and the mode bits from one another. The span between SCLK edges separates the divider and gap settings. Directed cases cover a command held during a conversion, result holding, and a short-window instance that must flag a timeout.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_XFER,
    ST_GAP,
    ST_TAIL
  } seq_state_e;

  localparam int BYTE_W     = 8;
  localparam int XFER_BYTES = 3;
  localparam int CODE_W     = 12;
  localparam int PAD_LO     = 3;

  // Control byte: start bit, select field, polarity, input mode, power bits.
  function automatic logic [7:0] make_ctrl(input logic [2:0] chan,
                                           input logic       single,
                                           input logic       unipolar,
                                           input logic [1:0] pwr);
    return {1'b1, chan[0], chan[2], chan[1], unipolar, single, pwr};
  endfunction

endpackage

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!en)        cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + CW'(1);
  end

  assign tick = en && (cnt == LAST);

endmodule

// File: rtl/adc_byte_shift.sv
module adc_byte_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         sclk,
  output logic         mosi,
  output logic         sample,
  output logic         byte_done
);
  localparam int BW = (W > 1) ? $clog2(W) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(W - 1);

  logic         sclk_q;
  logic [W-1:0] tx_q;
  logic [BW-1:0] bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
    end else if (run && tick) begin
      sclk_q <= !sclk_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      bit_q <= '0;
    end else if (load) begin
      tx_q  <= load_val;
      bit_q <= '0;
    end else if (run && tick && sclk_q) begin
      tx_q  <= tx_q << 1;
      bit_q <= (bit_q == LAST_BIT) ? '0 : bit_q + BW'(1);
    end
  end

  assign sclk      = sclk_q;
  assign mosi      = tx_q[W-1];
  assign sample    = run && tick && !sclk_q;
  assign byte_done = run && tick && sclk_q && (bit_q == LAST_BIT);

  // R10
  sclk_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk_q) |-> $past(run && tick));

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int LIMIT = 12000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic over
);
  localparam int CW = $clog2(LIMIT + 2);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (!run)                cnt <= '0;
    else if (cnt <= CW'(LIMIT))   cnt <= cnt + CW'(1);
  end

  assign over = cnt > CW'(LIMIT);

  // R9
  timer_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(run) |-> cnt >= $past(cnt));

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int         HALF_DIV      = 2,
  parameter int         GAP_SCLKS     = 2,
  parameter int         WINDOW_CYCLES = 12000,
  parameter logic [1:0] PWR_MODE      = 2'b11,
  parameter int         OUT_W         = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_chan,
  input  logic             cmd_single,
  input  logic             cmd_unipolar,
  output logic             busy,
  output logic             done,
  output logic             timeout_err,
  output logic [OUT_W-1:0] result,
  output logic             spi_sclk,
  output logic             spi_cs_n,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  localparam int RX_W      = CODE_W + PAD_LO;
  localparam int GAP_TICKS = 2 * GAP_SCLKS;
  localparam int GW        = (GAP_TICKS > 1) ? $clog2(GAP_TICKS) : 1;
  localparam logic [GW-1:0] GAP_LAST = GW'((GAP_TICKS > 0) ? GAP_TICKS - 1 : 0);
  localparam logic [1:0]    LAST_BYTE = 2'(XFER_BYTES - 1);

  seq_state_e        state;
  logic [1:0]        byte_idx;
  logic [GW-1:0]     gap_cnt;
  logic [RX_W-1:0]   rx_q;
  logic              uni_q;
  logic              cs_n_q;
  logic              done_q;
  logic              err_q;
  logic [OUT_W-1:0]  result_q;

  logic tick, sample, byte_done, accept, time_over, sh_load;
  logic [BYTE_W-1:0] sh_val;
  logic [CODE_W-1:0] code;
  logic [OUT_W-1:0]  code_ext;

  assign accept = cmd_valid && (state == ST_IDLE);

  adc_sclk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (state != ST_IDLE),
    .tick (tick)
  );

  assign sh_load = accept || (byte_done && (byte_idx != LAST_BYTE));
  assign sh_val  = accept ? make_ctrl(cmd_chan, cmd_single, cmd_unipolar, PWR_MODE)
                          : '0;

  adc_byte_shift #(.W(BYTE_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (state == ST_XFER),
    .tick     (tick),
    .load     (sh_load),
    .load_val (sh_val),
    .sclk     (spi_sclk),
    .mosi     (spi_mosi),
    .sample   (sample),
    .byte_done(byte_done)
  );

  adc_conv_timer #(.LIMIT(WINDOW_CYCLES)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (!cs_n_q),
    .over (time_over)
  );

  assign code = rx_q[RX_W-1:PAD_LO];

  generate
    if (OUT_W > CODE_W) begin : g_ext
      assign code_ext = uni_q ? {{(OUT_W-CODE_W){1'b0}}, code}
                              : {{(OUT_W-CODE_W){code[CODE_W-1]}}, code};
    end else begin : g_noext
      assign code_ext = code[OUT_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      byte_idx <= '0;
      gap_cnt  <= '0;
      rx_q     <= '0;
      uni_q    <= 1'b0;
      cs_n_q   <= 1'b1;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      result_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            cs_n_q   <= 1'b0;
            uni_q    <= cmd_unipolar;
            byte_idx <= '0;
            state    <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (tick) state <= ST_XFER;
        end
        ST_XFER: begin
          if (sample && (byte_idx != 2'd0)) rx_q <= {rx_q[RX_W-2:0], spi_miso};
          if (byte_done) begin
            if (byte_idx == LAST_BYTE) begin
              state <= ST_TAIL;
            end else begin
              byte_idx <= byte_idx + 2'd1;
              gap_cnt  <= '0;
              if (GAP_TICKS > 0) state <= ST_GAP;
            end
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (gap_cnt == GAP_LAST) state <= ST_XFER;
            else                     gap_cnt <= gap_cnt + GW'(1);
          end
        end
        ST_TAIL: begin
          if (tick) begin
            cs_n_q   <= 1'b1;
            done_q   <= 1'b1;
            err_q    <= time_over;
            result_q <= code_ext;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready   = (state == ST_IDLE);
  assign busy        = (state != ST_IDLE);
  assign done        = done_q;
  assign timeout_err = err_q;
  assign result      = result_q;
  assign spi_cs_n    = cs_n_q;

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> busy);

  // R1
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);

  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  // R2
  cs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> $past(cmd_valid && cmd_ready));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result) && $stable(timeout_err));

  // R8
  done_cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(spi_cs_n));

endmodule

// File: tb/adc_conv_seq_tb.sv
module adc_conv_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_DIV   = 2;
  localparam int GAP_SCLKS  = 2;
  localparam logic [1:0] PWR = 2'b11;
  localparam int SPAN = HALF_DIV * (42 + 2 * (2 + 2 * GAP_SCLKS));

  // {chan, single, unipolar, pad15, pad[2:0], code, expected result}
  localparam int NV = 8;
  localparam logic [36:0] VECS [NV] = '{
    {3'd0, 1'b1, 1'b1, 1'b0, 3'b000, 12'h000, 16'h0000},
    {3'd5, 1'b1, 1'b1, 1'b1, 3'b111, 12'hFFF, 16'h0FFF},
    {3'd3, 1'b0, 1'b0, 1'b0, 3'b000, 12'h800, 16'hF800},
    {3'd6, 1'b1, 1'b0, 1'b1, 3'b101, 12'h7FF, 16'h07FF},
    {3'd7, 1'b0, 1'b1, 1'b0, 3'b010, 12'hA5C, 16'h0A5C},
    {3'd2, 1'b1, 1'b0, 1'b1, 3'b000, 12'hFFF, 16'hFFFF},
    {3'd1, 1'b0, 1'b0, 1'b0, 3'b000, 12'h123, 16'h0123},
    {3'd4, 1'b1, 1'b1, 1'b0, 3'b001, 12'h800, 16'h0800}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_valid_t = 1'b0;
  logic [2:0] cmd_chan = '0;
  logic cmd_single = 1'b0, cmd_unipolar = 1'b0;
  logic cmd_ready, busy, done, timeout_err, spi_sclk, spi_cs_n, spi_mosi, spi_miso;
  logic [15:0] result;
  logic cmd_ready_t, busy_t, done_t, err_t, sclk_t, cs_t, mosi_t;
  logic [15:0] result_t;

  int checks = 0;
  int errors = 0;

  logic [23:0] adc_reply = '0;
  int          fall_cnt = 0;
  int          rise_cnt = 0;
  logic [23:0] mosi_cap = '0;
  time         t_first = 0, t_last = 0;

  always #(CLK_PERIOD/2) clk = !clk;

  adc_conv_seq #(.HALF_DIV(HALF_DIV), .GAP_SCLKS(GAP_SCLKS),
                 .WINDOW_CYCLES(12000), .PWR_MODE(PWR)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_chan(cmd_chan), .cmd_single(cmd_single), .cmd_unipolar(cmd_unipolar),
    .busy(busy), .done(done), .timeout_err(timeout_err), .result(result),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  adc_conv_seq #(.HALF_DIV(HALF_DIV), .GAP_SCLKS(GAP_SCLKS),
                 .WINDOW_CYCLES(40), .PWR_MODE(PWR)) u_dut_tmo (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid_t), .cmd_ready(cmd_ready_t),
    .cmd_chan(cmd_chan), .cmd_single(cmd_single), .cmd_unipolar(cmd_unipolar),
    .busy(busy_t), .done(done_t), .timeout_err(err_t), .result(result_t),
    .spi_sclk(sclk_t), .spi_cs_n(cs_t), .spi_mosi(mosi_t), .spi_miso(1'b0)
  );

  // Converter model: drives the next reply bit after each falling SCLK.
  always @(negedge spi_sclk or posedge spi_cs_n) begin
    if (spi_cs_n) fall_cnt = 0;
    else          fall_cnt = fall_cnt + 1;
  end
  assign spi_miso = (!spi_cs_n && fall_cnt < 24) ? adc_reply[23 - fall_cnt] : 1'b0;

  // Converter model: captures MOSI on rising SCLK.
  always @(posedge spi_sclk or negedge spi_cs_n) begin
    if (spi_sclk) begin
      if (rise_cnt == 0) t_first = $time;
      t_last   = $time;
      mosi_cap = {mosi_cap[22:0], spi_mosi};
      rise_cnt = rise_cnt + 1;
    end else begin
      rise_cnt = 0;
      mosi_cap = '0;
    end
  end

  function automatic logic [7:0] exp_ctrl(input logic [2:0] ch, input logic sg, input logic un);
    return {1'b1, ch[0], ch[2], ch[1], un, sg, PWR};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start_cmd(input logic [2:0] ch, input logic sg, input logic un);
    @(negedge clk);
    cmd_chan = ch; cmd_single = sg; cmd_unipolar = un; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; return; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit ok;
    logic [15:0] held;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    check("R2 reset cs_n", {31'd0, spi_cs_n}, 32'd1);
    check("R2 reset sclk", {31'd0, spi_sclk}, 32'd0);
    check("R1 reset ready/busy", {30'd0, cmd_ready, busy}, 32'd2);
    check("R8 reset done/result", {15'd0, done, result}, 32'd0);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      logic [36:0] e;
      e = VECS[v];
      adc_reply = {8'hA5, e[31], e[27:16], e[30:28]};
      start_cmd(e[36:34], e[33], e[32]);
      check("R1 busy after accept", {30'd0, busy, cmd_ready}, 32'd2);
      wait_done(ok);
      check("R8 done seen", {31'd0, ok}, 32'd1);
      check("R8 cs_n high with done", {31'd0, spi_cs_n}, 32'd1);
      check("R2 rising edge count", rise_cnt, 24);
      check("R3 control byte", {24'd0, mosi_cap[23:16]},
            {24'd0, exp_ctrl(e[36:34], e[33], e[32])});
      check("R4 zero bytes", {16'd0, mosi_cap[15:0]}, 32'd0);
      check(e[32] ? "R6 R7 unipolar result" : "R6 R7 bipolar result",
            {16'd0, result}, {16'd0, e[15:0]});
      check("R9 no timeout", {31'd0, timeout_err}, 32'd0);
      check("R10 edge span", 32'(t_last - t_first), 32'(SPAN * CLK_PERIOD));
      @(negedge clk);
      check("R8 done single cycle", {31'd0, done}, 32'd0);
    end

    // R5: a first reply byte of all ones must not reach the result
    adc_reply = {8'hFF, 1'b0, 12'h000, 3'b000};
    start_cmd(3'd0, 1'b1, 1'b1);
    wait_done(ok);
    check("R5 first reply byte discarded", {16'd0, result}, 32'd0);

    // R1: command held during a conversion is not taken
    adc_reply = {8'h00, 1'b0, 12'h321, 3'b000};
    start_cmd(3'd6, 1'b0, 1'b1);
    repeat (10) @(negedge clk);
    cmd_chan = 3'd1; cmd_single = 1'b1; cmd_unipolar = 1'b0; cmd_valid = 1'b1;
    repeat (20) @(negedge clk);
    check("R1 ready low while busy", {31'd0, cmd_ready}, 32'd0);
    cmd_valid = 1'b0;
    wait_done(ok);
    check("R1 first command kept", {24'd0, mosi_cap[23:16]}, {24'd0, exp_ctrl(3'd6, 1'b0, 1'b1)});
    check("R1 first result kept", {16'd0, result}, 32'h0321);
    held = result;
    repeat (40) @(negedge clk);
    check("R1 no second conversion", {31'd0, spi_cs_n}, 32'd1);
    check("R8 result held", {16'd0, result}, {16'd0, held});
    check("R8 done stays low", {31'd0, done}, 32'd0);

    // R9: short-window instance must flag a timeout
    @(negedge clk);
    cmd_valid_t = 1'b1;
    @(negedge clk);
    cmd_valid_t = 1'b0;
    ok = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done_t) begin ok = 1'b1; break; end
    end
    check("R9 timeout done seen", {31'd0, ok}, 32'd1);
    check("R9 timeout flag", {31'd0, err_t}, 32'd1);
    repeat (5) @(negedge clk);
    check("R8 timeout flag held", {31'd0, err_t}, 32'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule